// File: doc/BRIEF.md
# Nested Priority Event Controller

This block arbitrates sixteen prioritized event levels for a processor core. Level 0 has the highest priority and level 15 the lowest. Raised events are recorded in a latch register. A per-level mask register decides which latched levels may be taken. A pending register holds every level that has been accepted and not yet returned from, so it records how deeply the events are nested.

A latched level is accepted only when three things hold: its mask bit is set, it outranks every level already pending, and the blocking level (pending bit 4) is clear. On acceptance the controller moves the level from latch to pending in one step. It then offers the level number and its vector address to the core through a valid/ready handshake. The vector address is the table base plus four times the level number.

A return pulse from the core retires the most urgent pending level, and arbitration runs again afterwards. Software writes the mask register as a whole word. Writing ones to the latch register cancels latched events. A registered read port shows the mask, latch and pending registers.

Top module: `nest_evt_ctrl`

## Requirements
- R1: After synchronous reset, latch reads 0x0000, mask reads 0x0000, pending reads 0x8000 (only bit 15), and acc_valid_o is low.
- R2: A pulse on raise_i[k] sets latch bit k whether or not mask bit k is set. The bit stays set while the level is masked.
- R3: A latched level k is accepted only if mask bit k is 1 and k is smaller than the index of every set pending bit. A latched level that fails either condition is never offered.
- R4: Accepting level k sets pending bit k and clears latch bit k. Pending bits set earlier stay set.
- R5: While pending bit 4 is set, no level is accepted, not even an unmasked level that outranks it. Once bit 4 is cleared, the most urgent eligible latched level is accepted.
- R6: The offered vector acc_vector_o equals vec_base_i + 4 * acc_level_o, using vec_base_i as it was in the cycle before the offer appeared.
- R7: When several latched levels are eligible, only the lowest-numbered one is accepted. The others remain latched.
- R8: An offer appears two clock edges after the raise pulse or mask write that makes a level eligible. While acc_ready_i is low, acc_valid_o, acc_level_o and acc_vector_o hold their values and no new level is accepted.
- R9: A pulse on ret_i clears the lowest-numbered set pending bit, except that bit 15 is never cleared. No level is accepted in the cycle ret_i is high.
- R10: A write with wr_sel_i=1 clears each latch bit written as one. A raise of the same bit in the same cycle takes precedence, so the bit stays set.
- R11: A write with wr_sel_i=0 replaces the whole mask. rd_data_o is registered and shows the register chosen by rd_sel_i one edge later: 0 selects mask, 1 selects latch, 2 selects pending, and 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_i | input | 16 | Event raise pulses, one bit per level |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mask, 1 latch clear |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read select: 0 mask, 1 latch, 2 pending, 3 zero |
| rd_data_o | output | 16 | Registered read data |
| vec_base_i | input | 32 | Vector table base address |
| acc_valid_o | output | 1 | Accepted level offered to the core |
| acc_ready_i | input | 1 | Core takes the offer |
| acc_level_o | output | 4 | Offered level number |
| acc_vector_o | output | 32 | Offered vector address |
| ret_i | input | 1 | Return from the most urgent pending level |

## Verification
The assertions check the following on every cycle:
- the offer stays stable until it is taken;
- the vector matches the base and level;
- every new offer had its mask bit set and outranked all pending levels before it was taken;
- the pending register after an acceptance is exactly the earlier set plus the new level;
- nothing is accepted while bit 4 is pending or during a return cycle.

Some behaviour only the bench scenarios can show:
- whether the right level wins among several eligible ones;
- whether masked levels stay latched and are accepted later once unmasked or once a return uncovers them;
- whether a raise and a cancel of the same bit resolve in favour of the raise;
- whether a return leaves the lowest level in place.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    RD_MASK  = 2'd0,
    RD_LATCH = 2'd1,
    RD_PEND  = 2'd2,
    RD_ZERO  = 2'd3
  } rd_sel_e;

  typedef enum logic {
    WR_MASK  = 1'b0,
    WR_LATCH = 1'b1
  } wr_sel_e;
endpackage

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
  parameter int N  = 16,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [LW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = LW'(i);
    end
    found  = |vec;
    onehot = '0;
    if (found) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/evt_state.sv
module evt_state #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raise,
  input  logic         wr_mask_en,
  input  logic         wr_latch_en,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] take,
  input  logic [N-1:0] ret_clr,
  output logic [N-1:0] latch_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] pend_q
);
  localparam logic [N-1:0] PEND_RST = N'(1) << (N - 1);

  logic [N-1:0] cancel;
  assign cancel = wr_latch_en ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= '0;
      pend_q  <= PEND_RST;
    end else begin
      latch_q <= (latch_q & ~cancel & ~take) | raise;
      if (wr_mask_en) mask_q <= wr_data;
      pend_q  <= (pend_q & ~ret_clr) | take | PEND_RST;
    end
  end
endmodule

// File: rtl/evt_offer.sv
module evt_offer #(
  parameter int LW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_lvl,
  input  logic [AW-1:0] load_vec,
  input  logic          ready,
  output logic          valid,
  output logic [LW-1:0] lvl,
  output logic [AW-1:0] vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      lvl   <= '0;
      vec   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      lvl   <= load_lvl;
      vec   <= load_vec;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nest_evt_ctrl.sv
module nest_evt_ctrl #(
  parameter int NUM_LVL   = 16,
  parameter int ADDR_W    = 32,
  parameter int BLOCK_LVL = 4,
  parameter int VEC_SH    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_LVL-1:0]         raise_i,
  input  logic                       wr_en_i,
  input  logic                       wr_sel_i,
  input  logic [NUM_LVL-1:0]         wr_data_i,
  input  logic [1:0]                 rd_sel_i,
  output logic [NUM_LVL-1:0]         rd_data_o,
  input  logic [ADDR_W-1:0]          vec_base_i,
  output logic                       acc_valid_o,
  input  logic                       acc_ready_i,
  output logic [$clog2(NUM_LVL)-1:0] acc_level_o,
  output logic [ADDR_W-1:0]          acc_vector_o,
  input  logic                       ret_i
);
  import evt_pkg::*;

  localparam int LW = $clog2(NUM_LVL);

  logic [NUM_LVL-1:0] latch_q, mask_q, pend_q;
  logic [NUM_LVL-1:0] take, ret_clr, outrank, elig;
  logic [NUM_LVL-1:0] p_onehot, e_onehot;
  logic [LW-1:0]      p_idx, e_idx;
  logic               p_found, e_found, load;
  logic [ADDR_W-1:0]  load_vec;
  wr_sel_e            wsel;
  rd_sel_e            rsel;

  assign wsel = wr_sel_e'(wr_sel_i);
  assign rsel = rd_sel_e'(rd_sel_i);

  evt_state #(.N(NUM_LVL)) u_state (
    .clk(clk), .rst(rst), .raise(raise_i),
    .wr_mask_en(wr_en_i && wsel == WR_MASK),
    .wr_latch_en(wr_en_i && wsel == WR_LATCH),
    .wr_data(wr_data_i), .take(take), .ret_clr(ret_clr),
    .latch_q(latch_q), .mask_q(mask_q), .pend_q(pend_q)
  );

  evt_prio_enc #(.N(NUM_LVL), .LW(LW)) u_pend_enc (
    .vec(pend_q), .found(p_found), .idx(p_idx), .onehot(p_onehot)
  );

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_outrank
    assign outrank[g] = !p_found || (LW'(g) < p_idx);
  end

  assign elig = latch_q & mask_q & outrank;

  evt_prio_enc #(.N(NUM_LVL), .LW(LW)) u_elig_enc (
    .vec(elig), .found(e_found), .idx(e_idx), .onehot(e_onehot)
  );

  assign load     = e_found && !acc_valid_o && !ret_i && !pend_q[BLOCK_LVL];
  assign take     = load ? e_onehot : '0;
  assign ret_clr  = ret_i ? p_onehot : '0;
  assign load_vec = vec_base_i + (ADDR_W'(e_idx) << VEC_SH);

  evt_offer #(.LW(LW), .AW(ADDR_W)) u_offer (
    .clk(clk), .rst(rst), .load(load), .load_lvl(e_idx),
    .load_vec(load_vec), .ready(acc_ready_i),
    .valid(acc_valid_o), .lvl(acc_level_o), .vec(acc_vector_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      case (rsel)
        RD_MASK:  rd_data_o <= mask_q;
        RD_LATCH: rd_data_o <= latch_q;
        RD_PEND:  rd_data_o <= pend_q;
        default:  rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
  parameter int N     = 16,
  parameter int LW    = 4,
  parameter int AW    = 32,
  parameter int BLOCK = 4,
  parameter int SH    = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ret_i,
  input logic          acc_ready_i,
  input logic          acc_valid_o,
  input logic [LW-1:0] acc_level_o,
  input logic [AW-1:0] acc_vector_o,
  input logic [AW-1:0] vec_base_i,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  pend_q
);
  logic [N-1:0]  mask_d, pend_d, lvl_bit;
  logic [AW-1:0] base_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d <= '0;
      pend_d <= '0;
      base_d <= '0;
    end else begin
      mask_d <= mask_q;
      pend_d <= pend_q;
      base_d <= vec_base_i;
    end
  end

  assign lvl_bit = N'(1) << acc_level_o;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!acc_valid_o && pend_q == (N'(1) << (N - 1))));

  // R3: a new offer was unmasked and outranked all pending levels
  a_r3_eligible: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_valid_o) |-> (mask_d[acc_level_o] && ((pend_d & (lvl_bit | (lvl_bit - N'(1)))) == '0)));

  a_r4_pend_grows: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_valid_o) |-> (pend_q == (pend_d | lvl_bit)));

  a_r5_block: assert property (@(posedge clk) disable iff (rst)
    (pend_q[BLOCK] && !acc_valid_o) |=> !acc_valid_o);

  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_valid_o) |-> (acc_vector_o == base_d + (AW'(acc_level_o) << SH)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (acc_valid_o && !acc_ready_i) |=> (acc_valid_o && $stable(acc_level_o) && $stable(acc_vector_o)));

  a_r9_ret_stall: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> (!$rose(acc_valid_o) && pend_q[N-1]));
endmodule

bind nest_evt_ctrl evt_ctrl_chk #(
  .N(NUM_LVL), .LW($clog2(NUM_LVL)), .AW(ADDR_W), .BLOCK(BLOCK_LVL), .SH(VEC_SH)
) u_chk (
  .clk(clk), .rst(rst), .ret_i(ret_i), .acc_ready_i(acc_ready_i),
  .acc_valid_o(acc_valid_o), .acc_level_o(acc_level_o),
  .acc_vector_o(acc_vector_o), .vec_base_i(vec_base_i),
  .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/sim_nest_evt_ctrl.sv
module sim_nest_evt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 6;
  localparam logic [15:0] T_RAISE [NT] = '{16'h1260, 16'h1260, 16'h1260, 16'h8000, 16'h0001, 16'h0240};
  localparam logic [15:0] T_MASK  [NT] = '{16'h0000, 16'h1000, 16'hFFFF, 16'hFFFF, 16'h0001, 16'h0200};
  localparam int          T_LVL   [NT] = '{-1, 12, 5, -1, 0, 9};
  localparam logic [31:0] BASE = 32'h4000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raise_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [15:0] rd_data_o;
  logic [31:0] vec_base_i = BASE;
  logic        acc_valid_o;
  logic        acc_ready_i = 1'b0;
  logic [3:0]  acc_level_o;
  logic [31:0] acc_vector_o;
  logic        ret_i = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nest_evt_ctrl u0 (
    .clk(clk), .rst(rst), .raise_i(raise_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .vec_base_i(vec_base_i), .acc_valid_o(acc_valid_o),
    .acc_ready_i(acc_ready_i), .acc_level_o(acc_level_o),
    .acc_vector_o(acc_vector_o), .ret_i(ret_i)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; raise_i = '0; wr_en_i = 1'b0; acc_ready_i = 1'b0; ret_i = 1'b0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    cyc(1);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] b);
    raise_i = b;
    cyc(1);
    raise_i = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] v);
    rd_sel_i = sel;
    cyc(1);
    v = rd_data_o;
  endtask

  task automatic take();
    acc_ready_i = 1'b1;
    cyc(1);
    acc_ready_i = 1'b0;
  endtask

  task automatic do_ret();
    ret_i = 1'b1;
    cyc(1);
    ret_i = 1'b0;
  endtask

  task automatic chk_offer(input string tag, input int lvl);
    chk({tag, " valid"}, 32'(acc_valid_o), 32'(1));
    chk({tag, " level"}, 32'(acc_level_o), 32'(lvl));
    chk({tag, " vector"}, acc_vector_o, BASE + 32'(lvl) * 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 valid", 32'(acc_valid_o), 0);
    rd(2'd0, rv); chk("R1 mask", 32'(rv), 0);
    rd(2'd1, rv); chk("R1 latch", 32'(rv), 0);
    rd(2'd2, rv); chk("R1 pend", 32'(rv), 32'h8000);

    // Table: R2 R3 R6 R7 from a fresh reset each
    for (int t = 0; t < NT; t++) begin
      do_reset();
      wr(1'b0, T_MASK[t]);
      pulse(T_RAISE[t]);
      cyc(2);
      if (T_LVL[t] < 0) begin
        chk("R3 table no offer", 32'(acc_valid_o), 0);
        rd(2'd1, rv); chk("R2 table latch kept", 32'(rv), 32'(T_RAISE[t]));
      end else begin
        chk_offer("R7 R6 table", T_LVL[t]);
        rd(2'd1, rv);
        chk("R7 table rest latched", 32'(rv), 32'(T_RAISE[t] & ~(16'h1 << T_LVL[t])));
        rd(2'd2, rv);
        chk("R4 table pend", 32'(rv), 32'(16'h8000 | (16'h1 << T_LVL[t])));
      end
    end

    // R2 then R11: masked level stays latched, unmask by mask write
    do_reset();
    pulse(16'h0200);
    cyc(4);
    chk("R2 masked no offer", 32'(acc_valid_o), 0);
    rd(2'd1, rv); chk("R2 masked latched", 32'(rv), 32'h0200);
    wr(1'b0, 16'h0200);
    cyc(1);
    chk_offer("R8 unmask offer", 9);

    // Nesting: R4 R3 R9
    do_reset();
    wr(1'b0, 16'hFFFF);
    pulse(16'h1000); cyc(1);
    chk_offer("R4 first", 12);
    take();
    rd(2'd2, rv); chk("R4 pend 12", 32'(rv), 32'h9000);
    pulse(16'h0200); cyc(1);
    chk_offer("R4 nested", 9);
    take();
    rd(2'd2, rv); chk("R4 pend 12+9", 32'(rv), 32'h9200);
    pulse(16'h1000); cyc(3);
    chk("R3 lower not taken", 32'(acc_valid_o), 0);
    rd(2'd1, rv); chk("R3 lower latched", 32'(rv), 32'h1000);
    do_ret(); cyc(2);
    rd(2'd2, rv); chk("R9 ret clears 9", 32'(rv), 32'h9000);
    chk("R3 equal not taken", 32'(acc_valid_o), 0);
    do_ret(); cyc(1);
    chk_offer("R9 after ret", 12);
    take();
    do_ret(); cyc(1);
    do_ret(); cyc(1);
    rd(2'd2, rv); chk("R9 bit15 kept", 32'(rv), 32'h8000);

    // R5: blocking level
    do_reset();
    wr(1'b0, 16'hFFFF);
    pulse(16'h0010); cyc(1);
    chk_offer("R5 accept 4", 4);
    take();
    pulse(16'h0021); cyc(3);
    chk("R5 blocked", 32'(acc_valid_o), 0);
    rd(2'd1, rv); chk("R5 latched while blocked", 32'(rv), 32'h0021);
    do_ret(); cyc(1);
    chk_offer("R5 unblocked", 0);
    rd(2'd1, rv); chk("R7 5 stays latched", 32'(rv), 32'h0020);

    // R8: hold while not ready, then second offer
    do_reset();
    wr(1'b0, 16'hFFFF);
    pulse(16'h0080); cyc(1);
    chk_offer("R8 first", 7);
    pulse(16'h0004); cyc(4);
    chk_offer("R8 held", 7);
    take(); cyc(1);
    chk_offer("R8 second", 2);

    // R10: latch cancel
    do_reset();
    pulse(16'h0008);
    rd(2'd1, rv); chk("R10 set", 32'(rv), 32'h0008);
    wr(1'b1, 16'h0008);
    rd(2'd1, rv); chk("R10 cancel", 32'(rv), 32'h0000);
    raise_i = 16'h0008; wr_en_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 16'h0008;
    cyc(1);
    raise_i = '0; wr_en_i = 1'b0;
    rd(2'd1, rv); chk("R10 raise wins", 32'(rv), 32'h0008);
    pulse(16'h0030);
    wr(1'b1, 16'h0010);
    rd(2'd1, rv); chk("R10 partial cancel", 32'(rv), 32'h0028);

    // R11: mask replace and read select
    wr(1'b0, 16'h00F0);
    rd(2'd0, rv); chk("R11 mask", 32'(rv), 32'h00F0);
    wr(1'b0, 16'h0003);
    rd(2'd0, rv); chk("R11 mask replaced", 32'(rv), 32'h0003);
    rd(2'd3, rv); chk("R11 zero select", 32'(rv), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule